// File: doc/BRIEF.md
# Dual-Clock Programmable-Flag FIFO

This block is a first-in-first-out buffer for 18-bit words whose write side and read side run on unrelated clocks. There is no limit on the ratio between the two clock frequencies. The write pointer and the read pointer each cross to the other domain as a Gray code through a two-stage synchronizer. Each side then works out its own fill count from its own pointer and the synchronized copy of the other.

The block reports status on both sides: an empty-or-valid flag, a full-or-ready flag, half-full, almost-empty and almost-full. The two almost thresholds are offsets. A master reset sets both offsets to one of two preset values, chosen by a strap input. Software can then load them as two parallel words through the data input, or as a serial bit stream. A strap sampled during master reset picks one of two output timings. In standard timing, each word needs a read request. In first-word-fall-through timing, the head word is presented on its own and is consumed by a read. A partial reset empties the buffer but keeps the offsets and the timing choice. Retransmit rewinds the read side to location zero so the stored data can be read again. An output enable releases the data outputs to high impedance.

Top module: `xclk_flag_fifo`

## Requirements
- R1: During and after master reset the buffer is empty, data output is 0. Both offsets become 127 mod DEPTH when `presetSel`=0, or 1023 mod DEPTH when `presetSel`=1.
- R2: Standard timing. Words come out in write order. A word appears on `rdData` after the `rdClk` edge that samples `rdEn` high. `emptyOrValid` is 1 exactly when no word is readable.
- R3: Standard timing: `fullOrReady` is 1 when DEPTH words are stored. A write while full is ignored and the stored data stays unchanged.
- R4: A read while empty is ignored. It changes neither `rdData` nor the read position.
- R5: `halfFull` is 1 when the stored count is greater than DEPTH/2.
- R6: `almostEmpty` is 1 when the stored count is at or below the almost-empty offset.
- R7: `almostFull` is 1 when DEPTH minus the stored count is at or below the almost-full offset.
- R8: A write with `loadEn` high stores `wrData[AW-1:0]` as an offset instead of queuing a word. AW is log2(DEPTH). The first such load after a reset goes to the almost-empty offset, the next to the almost-full offset, and so on alternately.
- R9: While `serEn` is high, each `wrClk` edge takes one bit from `serInFwft`. The first AW bits fill the almost-empty offset LSB first. The next AW bits fill the almost-full offset LSB first. The sequence then wraps.
- R10: A partial reset empties the buffer but keeps both offsets and the timing mode.
- R11: `serInFwft` high during master reset selects fall-through timing. In that mode `emptyOrValid` means a valid word is on the output, and `fullOrReady` means space is free. The head word appears with no read request. A read moves on to the next word.
- R12: A `retransmit` pulse rewinds reading to location 0. In standard timing the next read returns the first word. In fall-through timing the first word is presented by the second `rdClk` edge after the pulse.
- R13: With `outEn` low, `rdData` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| masterRst | input | 1 | Master reset, active high, asynchronous for the pointers |
| partialRst | input | 1 | Partial reset, active high |
| presetSel | input | 1 | Selects the default offset during master reset |
| wrClk | input | 1 | Write clock |
| wrEn | input | 1 | Write enable |
| wrData | input | 18 | Write data, also the source for parallel offset loads |
| loadEn | input | 1 | Turns writes into offset loads |
| serEn | input | 1 | Serial offset load enable |
| serInFwft | input | 1 | Timing strap during master reset, serial offset bit afterwards |
| fullOrReady | output | 1 | Full (standard) or input-ready (fall-through) |
| halfFull | output | 1 | Count above half the depth |
| almostFull | output | 1 | Free space at or below the almost-full offset |
| rdClk | input | 1 | Read clock |
| rdEn | input | 1 | Read enable |
| retransmit | input | 1 | Rewind reading to location 0 |
| outEn | input | 1 | Output enable for the data outputs |
| rdData | output | 18 | Read data |
| emptyOrValid | output | 1 | Empty (standard) or output-valid (fall-through) |
| almostEmpty | output | 1 | Count at or below the almost-empty offset |

## Verification
Traffic is written in short bursts. Flags are read only after the pointers have had time to cross, so each flag is checked at exact counts on both sides of its threshold. This separates off-by-one compare errors from threshold errors. The flag thresholds are checked four ways: with the two preset offsets, with parallel-loaded offsets and with serially loaded offsets. This shows which offset register each path fills, and in which bit order. Writes past full and reads past empty are followed by a full readback and by a fresh word. That separates a real ignore from one that silently moves a pointer. Both timing modes are run through reads, retransmit and partial reset, so a design that drops the mode on partial reset shows up in the flag polarity.

// File: rtl/xff_pkg.sv
package xff_pkg;
  // Strobes from control to datapath, one per storage action.
  typedef struct packed {
    logic memWe;    // write-domain: store wrData at wrAddr
    logic outLoad;  // read-domain: capture the word at rdAddr
  } xffStrobe_t;
endpackage

// File: rtl/xff_ctrl.sv
module xff_ctrl
  import xff_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          masterRst,
  input  logic          partialRst,
  input  logic          presetSel,
  input  logic          wrClk,
  input  logic          wrEn,
  input  logic          loadEn,
  input  logic          serEn,
  input  logic          serInFwft,
  input  logic [AW-1:0] ofsData,
  input  logic          rdClk,
  input  logic          rdEn,
  input  logic          retransmit,
  output xffStrobe_t    stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          fwftMode,
  output logic          fullOrReady,
  output logic          halfFull,
  output logic          almostFull,
  output logic          emptyOrValid,
  output logic          almostEmpty
);
  localparam int PW = AW + 1;
  localparam int CW = $clog2(2 * AW) + 1;
  localparam logic [AW-1:0] PRESET_LO = AW'(127 % DEPTH);
  localparam logic [AW-1:0] PRESET_HI = AW'(1023 % DEPTH);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic rstAny;
  assign rstAny = masterRst | partialRst;

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrGray, rgSyncA, rgSyncB, rdGray, wrCount;
  logic [AW-1:0] aeOff, afOff;
  logic          ldSel, full, push;
  logic [CW-1:0] serCnt;

  assign wrCount = wrBin - gray2bin(rgSyncB);
  assign full    = (wrCount == FULL_CNT);
  assign push    = wrEn && !loadEn && !full;

  always_ff @(posedge wrClk or posedge rstAny) begin
    if (rstAny) begin
      wrBin   <= '0;
      wrGray  <= '0;
      rgSyncA <= '0;
      rgSyncB <= '0;
    end else begin
      rgSyncA <= rdGray;
      rgSyncB <= rgSyncA;
      if (push) begin
        wrBin  <= wrBin + PW'(1);
        wrGray <= bin2gray(wrBin + PW'(1));
      end
    end
  end

  // Offsets and timing mode: loaded synchronously, survive partial reset.
  always_ff @(posedge wrClk) begin
    if (masterRst) begin
      aeOff    <= presetSel ? PRESET_HI : PRESET_LO;
      afOff    <= presetSel ? PRESET_HI : PRESET_LO;
      fwftMode <= serInFwft;
      ldSel    <= 1'b0;
      serCnt   <= '0;
    end else if (partialRst) begin
      ldSel  <= 1'b0;
      serCnt <= '0;
    end else if (loadEn && wrEn) begin
      if (!ldSel) aeOff <= ofsData;
      else        afOff <= ofsData;
      ldSel <= !ldSel;
    end else if (serEn) begin
      for (int b = 0; b < AW; b++) begin
        if (serCnt == CW'(b))      aeOff[b] <= serInFwft;
        if (serCnt == CW'(b + AW)) afOff[b] <= serInFwft;
      end
      serCnt <= (serCnt == CW'(2 * AW - 1)) ? '0 : serCnt + CW'(1);
    end
  end

  assign fullOrReady = fwftMode ? !full : full;
  assign halfFull    = (wrCount > HALF_CNT);
  assign almostFull  = ((FULL_CNT - wrCount) <= {1'b0, afOff});

  // ---------------- read domain ----------------
  logic [PW-1:0] rdBin, wgSyncA, wgSyncB, rdCount;
  logic          outValid, memEmpty, pop;

  assign rdCount  = gray2bin(wgSyncB) - rdBin;
  assign memEmpty = (rdCount == '0);
  assign pop      = !retransmit && !memEmpty && (fwftMode ? (!outValid || rdEn) : rdEn);

  always_ff @(posedge rdClk or posedge rstAny) begin
    if (rstAny) begin
      rdBin    <= '0;
      rdGray   <= '0;
      wgSyncA  <= '0;
      wgSyncB  <= '0;
      outValid <= 1'b0;
    end else begin
      wgSyncA <= wrGray;
      wgSyncB <= wgSyncA;
      if (retransmit) begin
        rdBin    <= '0;
        rdGray   <= '0;
        outValid <= 1'b0;
      end else begin
        if (pop) begin
          rdBin  <= rdBin + PW'(1);
          rdGray <= bin2gray(rdBin + PW'(1));
        end
        if (fwftMode) begin
          if (pop)       outValid <= 1'b1;
          else if (rdEn) outValid <= 1'b0;
        end
      end
    end
  end

  assign emptyOrValid = fwftMode ? outValid : memEmpty;
  assign almostEmpty  = (rdCount <= {1'b0, aeOff});

  assign stb.memWe   = push;
  assign stb.outLoad = pop;
  assign wrAddr      = wrBin[AW-1:0];
  assign rdAddr      = rdBin[AW-1:0];
endmodule

// File: rtl/xff_datapath.sv
module xff_datapath
  import xff_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 18,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstAny,
  input  xffStrobe_t       stb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic             outEn,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] store [DEPTH];
  logic [WIDTH-1:0] outQ;

  always_ff @(posedge wrClk) begin
    if (stb.memWe) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or posedge rstAny) begin
    if (rstAny)           outQ <= '0;
    else if (stb.outLoad) outQ <= store[rdAddr];
  end

  assign rdData = outEn ? outQ : 'z;
endmodule

// File: rtl/xclk_flag_fifo.sv
module xclk_flag_fifo
  import xff_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 18,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             masterRst,
  input  logic             partialRst,
  input  logic             presetSel,
  input  logic             wrClk,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             loadEn,
  input  logic             serEn,
  input  logic             serInFwft,
  output logic             fullOrReady,
  output logic             halfFull,
  output logic             almostFull,
  input  logic             rdClk,
  input  logic             rdEn,
  input  logic             retransmit,
  input  logic             outEn,
  output logic [WIDTH-1:0] rdData,
  output logic             emptyOrValid,
  output logic             almostEmpty
);
  xffStrobe_t    stb;
  logic [AW-1:0] wrAddr, rdAddr;
  logic          fwftMode;

  xff_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .masterRst(masterRst), .partialRst(partialRst), .presetSel(presetSel),
    .wrClk(wrClk), .wrEn(wrEn), .loadEn(loadEn), .serEn(serEn),
    .serInFwft(serInFwft), .ofsData(wrData[AW-1:0]),
    .rdClk(rdClk), .rdEn(rdEn), .retransmit(retransmit),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr), .fwftMode(fwftMode),
    .fullOrReady(fullOrReady), .halfFull(halfFull), .almostFull(almostFull),
    .emptyOrValid(emptyOrValid), .almostEmpty(almostEmpty)
  );

  xff_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dp_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstAny(masterRst | partialRst),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData),
    .outEn(outEn), .rdData(rdData)
  );
endmodule

// File: rtl/xff_checker.sv
module xff_checker
  import xff_pkg::*;
(
  input logic       wrClk,
  input logic       rdClk,
  input logic       masterRst,
  input logic       partialRst,
  input logic       rdEn,
  input logic       retransmit,
  input logic       fwftMode,
  input xffStrobe_t stb,
  input logic       fullOrReady,
  input logic       halfFull,
  input logic       almostFull,
  input logic       emptyOrValid,
  input logic       almostEmpty
);
  logic rstAny;
  assign rstAny = masterRst | partialRst;

  AST_NO_OVERFLOW: assert property (@(posedge wrClk) disable iff (rstAny)
    (fwftMode ? !fullOrReady : fullOrReady) |-> !stb.memWe); // R3

  AST_NO_UNDERFLOW: assert property (@(posedge rdClk) disable iff (rstAny)
    (!fwftMode && emptyOrValid) |-> !stb.outLoad); // R4

  AST_FULL_ABOVE_HALF: assert property (@(posedge wrClk) disable iff (rstAny)
    (!fwftMode && fullOrReady) |-> (halfFull && almostFull)); // R5

  AST_EMPTY_IS_LOW: assert property (@(posedge rdClk) disable iff (rstAny)
    (!fwftMode && emptyOrValid) |-> almostEmpty); // R6

  AST_FWFT_HOLD: assert property (@(posedge rdClk) disable iff (rstAny)
    (fwftMode && emptyOrValid && !rdEn && !retransmit) |=> emptyOrValid); // R11

  AST_MODE_KEPT: assert property (@(posedge wrClk) disable iff (masterRst)
    !masterRst |=> $stable(fwftMode)); // R10
endmodule

bind xclk_flag_fifo xff_checker chk_i (
  .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .partialRst(partialRst),
  .rdEn(rdEn), .retransmit(retransmit), .fwftMode(fwftMode), .stb(stb),
  .fullOrReady(fullOrReady), .halfFull(halfFull), .almostFull(almostFull),
  .emptyOrValid(emptyOrValid), .almostEmpty(almostEmpty)
);

// File: tb/xclk_flag_fifo_tb.sv
`timescale 1ns/100ps
module xclk_flag_fifo_tb_top;
  localparam int DEPTH = 256;
  localparam int AW = 8;

  logic masterRst = 1'b1, partialRst = 1'b0, presetSel = 1'b0;
  logic wrClk = 1'b0, wrEn = 1'b0, loadEn = 1'b0, serEn = 1'b0, serInFwft = 1'b0;
  logic [17:0] wrData = '0;
  logic rdClk = 1'b0, rdEn = 1'b0, retransmit = 1'b0, outEn = 1'b1;
  wire  [17:0] rdData;
  wire  fullOrReady, halfFull, almostFull, emptyOrValid, almostEmpty;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4    wrClk = ~wrClk;   // 125 MHz
  always #5.5  rdClk = ~rdClk;

  xclk_flag_fifo #(.DEPTH(DEPTH)) dut_i (
    .masterRst(masterRst), .partialRst(partialRst), .presetSel(presetSel),
    .wrClk(wrClk), .wrEn(wrEn), .wrData(wrData), .loadEn(loadEn), .serEn(serEn),
    .serInFwft(serInFwft), .fullOrReady(fullOrReady), .halfFull(halfFull),
    .almostFull(almostFull), .rdClk(rdClk), .rdEn(rdEn), .retransmit(retransmit),
    .outEn(outEn), .rdData(rdData), .emptyOrValid(emptyOrValid),
    .almostEmpty(almostEmpty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge wrClk);
    repeat (6) @(negedge rdClk);
  endtask

  task automatic doMaster(input logic sel, input logic fwft);
    @(negedge wrClk);
    masterRst = 1'b1; presetSel = sel; serInFwft = fwft;
    repeat (4) @(negedge wrClk);
    repeat (3) @(negedge rdClk);
    @(negedge wrClk);
    masterRst = 1'b0; serInFwft = 1'b0;
    settle();
  endtask

  task automatic doPartial();
    @(negedge wrClk);
    partialRst = 1'b1;
    repeat (4) @(negedge wrClk);
    repeat (3) @(negedge rdClk);
    @(negedge wrClk);
    partialRst = 1'b0;
    settle();
  endtask

  task automatic writeBurst(input int n, input logic [17:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      wrEn = 1'b1; wrData = base + 18'(i);
    end
    @(negedge wrClk);
    wrEn = 1'b0;
    settle();
  endtask

  task automatic readOne(output logic [17:0] d);
    @(negedge rdClk); rdEn = 1'b1;
    @(negedge rdClk); rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic pulseRetransmit();
    @(negedge rdClk); retransmit = 1'b1;
    @(negedge rdClk); retransmit = 1'b0;
  endtask

  task automatic t_reset();
    doMaster(1'b0, 1'b0);
    chk("R1 empty", 32'(emptyOrValid), 1);
    chk("R1 full", 32'(fullOrReady), 0);
    chk("R1 half", 32'(halfFull), 0);
    chk("R1 ae", 32'(almostEmpty), 1);
    chk("R1 af", 32'(almostFull), 0);
    chk("R1 data", 32'(rdData), 0);
  endtask

  task automatic t_order();
    logic [17:0] d;
    doMaster(1'b0, 1'b0);
    writeBurst(5, 18'h1000);
    chk("R2 not empty", 32'(emptyOrValid), 0);
    for (int i = 0; i < 5; i++) begin
      readOne(d);
      chk("R2 order", 32'(d), 32'(18'h1000 + 18'(i)));
    end
    settle();
    chk("R2 empty again", 32'(emptyOrValid), 1);
    readOne(d);
    chk("R4 read while empty holds data", 32'(d), 32'h1004);
    writeBurst(1, 18'h2222);
    readOne(d);
    chk("R4 pointer unmoved", 32'(d), 32'h2222);
  endtask

  task automatic t_fill();
    logic [17:0] d;
    int errs;
    doMaster(1'b0, 1'b0);
    writeBurst(127, 18'h100);
    chk("R6 ae at 127", 32'(almostEmpty), 1);
    chk("R7 af at 127", 32'(almostFull), 0);
    writeBurst(1, 18'h100 + 18'd127);
    chk("R6 ae at 128", 32'(almostEmpty), 0);
    chk("R5 half at 128", 32'(halfFull), 0);
    chk("R7 af at 128", 32'(almostFull), 0);
    writeBurst(1, 18'h100 + 18'd128);
    chk("R5 half at 129", 32'(halfFull), 1);
    chk("R7 af at 129", 32'(almostFull), 1);
    writeBurst(126, 18'h100 + 18'd129);
    chk("R3 not full at 255", 32'(fullOrReady), 0);
    writeBurst(1, 18'h100 + 18'd255);
    chk("R3 full at 256", 32'(fullOrReady), 1);
    writeBurst(1, 18'h3FFFF);
    errs = 0;
    for (int i = 0; i < DEPTH; i++) begin
      readOne(d);
      if (d !== 18'h100 + 18'(i)) errs++;
    end
    chk("R3 readback after overflow", 32'(errs), 0);
    settle();
    chk("R3 nothing extra stored", 32'(emptyOrValid), 1);
  endtask

  task automatic t_preset1();
    doMaster(1'b1, 1'b0);
    chk("R1 af preset 255 at 0", 32'(almostFull), 0);
    writeBurst(1, 18'h10);
    chk("R1 af preset 255 at 1", 32'(almostFull), 1);
    writeBurst(254, 18'h11);
    chk("R1 ae preset 255 at 255", 32'(almostEmpty), 1);
    writeBurst(1, 18'h20);
    chk("R1 ae preset 255 at 256", 32'(almostEmpty), 0);
  endtask

  task automatic t_parallelAndPartial();
    doMaster(1'b0, 1'b0);
    @(negedge wrClk); loadEn = 1'b1; wrEn = 1'b1; wrData = 18'd10;
    @(negedge wrClk); wrData = 18'd20;
    @(negedge wrClk); loadEn = 1'b0; wrEn = 1'b0;
    settle();
    chk("R8 load not queued", 32'(emptyOrValid), 1);
    writeBurst(10, 18'h40);
    chk("R8 ae=10 at 10", 32'(almostEmpty), 1);
    writeBurst(1, 18'h50);
    chk("R8 ae=10 at 11", 32'(almostEmpty), 0);
    writeBurst(224, 18'h60);
    chk("R8 af=20 at 235", 32'(almostFull), 0);
    writeBurst(1, 18'h70);
    chk("R8 af=20 at 236", 32'(almostFull), 1);
    doPartial();
    chk("R10 emptied", 32'(emptyOrValid), 1);
    writeBurst(10, 18'h80);
    chk("R10 ae kept at 10", 32'(almostEmpty), 1);
    writeBurst(1, 18'h90);
    chk("R10 ae kept at 11", 32'(almostEmpty), 0);
  endtask

  task automatic t_serial();
    logic [15:0] bits;
    bits = {8'd3, 8'd5};
    doMaster(1'b0, 1'b0);
    for (int b = 0; b < 2 * AW; b++) begin
      @(negedge wrClk); serEn = 1'b1; serInFwft = bits[b];
    end
    @(negedge wrClk); serEn = 1'b0; serInFwft = 1'b0;
    settle();
    writeBurst(5, 18'h200);
    chk("R9 ae=5 at 5", 32'(almostEmpty), 1);
    writeBurst(1, 18'h205);
    chk("R9 ae=5 at 6", 32'(almostEmpty), 0);
    writeBurst(246, 18'h206);
    chk("R9 af=3 at 252", 32'(almostFull), 0);
    writeBurst(1, 18'h300);
    chk("R9 af=3 at 253", 32'(almostFull), 1);
  endtask

  task automatic t_fwft();
    logic [17:0] d;
    doMaster(1'b0, 1'b1);
    chk("R11 input ready", 32'(fullOrReady), 1);
    chk("R11 no valid", 32'(emptyOrValid), 0);
    writeBurst(3, 18'h500);
    chk("R11 falls through valid", 32'(emptyOrValid), 1);
    chk("R11 first word shown", 32'(rdData), 32'h500);
    readOne(d);
    chk("R11 second word", 32'(d), 32'h501);
    readOne(d);
    chk("R11 third word", 32'(d), 32'h502);
    readOne(d);
    chk("R11 drained", 32'(emptyOrValid), 0);
    doPartial();
    chk("R10 mode kept", 32'(fullOrReady), 1);
  endtask

  task automatic t_retransmit();
    logic [17:0] d;
    doMaster(1'b0, 1'b0);
    writeBurst(4, 18'h700);
    for (int i = 0; i < 4; i++) readOne(d);
    pulseRetransmit();
    readOne(d);
    chk("R12 std first again", 32'(d), 32'h700);
    readOne(d);
    chk("R12 std second again", 32'(d), 32'h701);
    doMaster(1'b0, 1'b1);
    writeBurst(3, 18'h900);
    readOne(d);
    readOne(d);
    chk("R12 fwft before rewind", 32'(d), 32'h902);
    pulseRetransmit();
    @(negedge rdClk);
    chk("R12 fwft rewound data", 32'(rdData), 32'h900);
    chk("R12 fwft rewound valid", 32'(emptyOrValid), 1);
  endtask

  task automatic t_outEn();
    logic ok;
    doMaster(1'b0, 1'b0);
    writeBurst(1, 18'h2ABCD);
    @(negedge rdClk); rdEn = 1'b1;
    @(negedge rdClk); rdEn = 1'b0; outEn = 1'b0;
    #1;
    ok = (rdData === {18{1'bz}}) || (rdData === 18'd0);
    chk("R13 released", 32'(ok), 1);
    outEn = 1'b1;
    #1;
    chk("R13 driven again", 32'(rdData), 32'h2ABCD);
  endtask

  initial begin : watchdog
    #400us;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : mainSeq
    t_reset();
    t_order();
    t_fill();
    t_preset1();
    t_parallelAndPartial();
    t_serial();
    t_fwft();
    t_retransmit();
    t_outEn();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule